// File: doc/BRIEF.md
# Three-Phase Overlevel Detector with Interrupt

This block watches the voltage and current samples of a three-phase system and raises a flag whenever any phase produces a sample whose magnitude lies above a programmable level. There is one level for voltage and one for current. Each level is a 24-bit unsigned number. It is compared against the absolute value of the signed sample, so positive and negative excursions are treated alike. Two level values are special. A level of zero flags every valid sample. A level at or above the largest magnitude the upstream filter can produce (5,928,256) disables detection altogether.

Each event sets a sticky summary bit in a status word. It also records, in a separate phase-status word, which phases fired. When a summary bit is set and its mask bit is enabled, the active-low interrupt line is pulled low. Host software reads the status word, then reads the phase-status word to find the offending phase. It then writes a one to the summary bit, which clears that bit, clears its phase field and releases the interrupt. Host access uses a simple read/write strobe interface with 32-bit data words.

Top module: `phase_overlevel_irq`

## Requirements
- R1: After synchronous reset, all five registers read zero and `irq_n` is high. The register map is: address 0 status, 1 phase status, 2 mask, 3 voltage level, 4 current level. A read strobe at one clock edge places the data on `reg_rdata` after that edge.
- R2: A current sample accepted with `i_vld` high whose magnitude is strictly greater than the current level sets status bit 17 at that clock edge. It also sets phase-status bit 3+p for phase p (A=0, B=1, C=2). A magnitude equal to the level sets nothing.
- R3: A voltage sample accepted with `v_vld` high whose magnitude is strictly greater than the voltage level sets status bit 18 and phase-status bit 9+p at that clock edge.
- R4: Negative samples are compared by their absolute value, including the most negative 24-bit code.
- R5: Samples presented while their valid strobe is low change no status or phase bit.
- R6: A level of 5,928,256 or more never detects, even for a full-range sample of either sign.
- R7: A level of zero detects on every valid sample of every phase, including a zero sample.
- R8: The mask register holds enables at bits 17 (current) and 18 (voltage). `irq_n` is a register that goes low one clock after a status bit and its mask bit are both set. It returns high one clock after no enabled status bit remains.
- R9: A write to the status address with bit 17 (or 18) set clears that summary bit and its whole phase field. A write with the bit at zero leaves the bit and its field unchanged.
- R10: If a detection and a clearing write fall on the same clock edge, the summary bit stays set and its phase field holds only the phases of the new detection.
- R11: Level registers keep the low 24 bits written. A read returns them with bits 31:24 zero. Status and mask keep only bits 17 and 18.
- R12: Phase fields are sticky and accumulate every phase that fired until they are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v_smp | input | 72 | Voltage samples, phase p in bits [24p+23:24p], signed |
| v_vld | input | 1 | Voltage samples valid this cycle |
| i_smp | input | 72 | Current samples, phase p in bits [24p+23:24p], signed |
| i_vld | input | 1 | Current samples valid this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
The bench builds the block with its default parameters: 24-bit samples and levels, three phases, and a saturation level of 5,928,256. These values let the bench reach the full-scale disable level, a level above it, and the most negative 24-bit sample code, whose absolute value needs a 25th bit. Three phases are enough to check that the phase fields accumulate, and to check the same-edge clear-versus-detect race on a phase other than the one that was cleared.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int REG_DW    = 32;
  localparam int ADDR_W    = 3;
  localparam int OI_BIT    = 17;
  localparam int OV_BIT    = 18;
  localparam int OI_PH_LSB = 3;
  localparam int OV_PH_LSB = 9;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 3'd0,
    RA_PHASE  = 3'd1,
    RA_MASK   = 3'd2,
    RA_VLEVEL = 3'd3,
    RA_ILEVEL = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/ovl_phase_cmp.sv
module ovl_phase_cmp #(
  parameter int SAMPLE_W   = 24,
  parameter int LEVEL_W    = 24,
  parameter int NUM_PH     = 3,
  parameter int FULL_SCALE = 5928256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PH*SAMPLE_W-1:0] smp,
  input  logic                       vld,
  input  logic [LEVEL_W-1:0]         lvl,
  output logic [NUM_PH-1:0]          hit
);
  localparam int MAG_W = SAMPLE_W + 1;
  localparam int CMP_W = (MAG_W > LEVEL_W) ? MAG_W : LEVEL_W;
  localparam logic [LEVEL_W-1:0] FS_L = LEVEL_W'(FULL_SCALE);

  logic lvl_dead;
  logic lvl_all;

  assign lvl_dead = (lvl >= FS_L);
  assign lvl_all  = (lvl == '0);

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    logic signed [MAG_W-1:0] ext;
    logic        [MAG_W-1:0] mag;
    logic                    above;

    assign ext   = {smp[p*SAMPLE_W+SAMPLE_W-1], smp[p*SAMPLE_W +: SAMPLE_W]};
    assign mag   = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
    assign above = CMP_W'(mag) > CMP_W'(lvl);
    assign hit[p] = vld && !lvl_dead && (lvl_all || above);
  end

  // R5
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |-> (hit == '0));
  // R6
  saturated_level_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_dead |-> (hit == '0));
  // R7
  zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && lvl_all) |-> (hit == {NUM_PH{1'b1}}));
endmodule

// File: rtl/ovl_sticky.sv
module ovl_sticky #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PH-1:0] hit,
  input  logic              clr,
  output logic              flag,
  output logic [NUM_PH-1:0] phases
);
  logic              any_hit;
  logic              flag_d;
  logic [NUM_PH-1:0] ph_d;

  assign any_hit = |hit;

  always_comb begin
    flag_d = any_hit | (flag & ~clr);
    ph_d   = hit | (clr ? '0 : phases);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      phases <= '0;
    end else begin
      flag   <= flag_d;
      phases <= ph_d;
    end
  end

  // R2
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> flag);
  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !any_hit) |=> (!flag && phases == '0));
  // R10
  race_keeps_new_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && any_hit) |=> (flag && phases == $past(hit)));
  // R12
  phase_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((phases & $past(phases)) == $past(phases)));
endmodule

// File: rtl/ovl_regs.sv
module ovl_regs
  import ovl_pkg::*;
#(
  parameter int LEVEL_W = 24,
  parameter int NUM_PH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              oi_flag,
  input  logic              ov_flag,
  input  logic [NUM_PH-1:0] oi_ph,
  input  logic [NUM_PH-1:0] ov_ph,
  output logic              mask_oi,
  output logic              mask_ov,
  output logic [LEVEL_W-1:0] vlev,
  output logic [LEVEL_W-1:0] ilev,
  output logic              clr_oi,
  output logic              clr_ov,
  output logic [REG_DW-1:0] rdata
);
  logic              wr_stat;
  logic              wr_mask;
  logic              wr_vlev;
  logic              wr_ilev;
  logic [REG_DW-1:0] rd_word;
  logic              unused_wbits;

  assign wr_stat = wr && (addr == RA_STATUS);
  assign wr_mask = wr && (addr == RA_MASK);
  assign wr_vlev = wr && (addr == RA_VLEVEL);
  assign wr_ilev = wr && (addr == RA_ILEVEL);
  assign clr_oi  = wr_stat && wdata[OI_BIT];
  assign clr_ov  = wr_stat && wdata[OV_BIT];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_oi <= 1'b0;
      mask_ov <= 1'b0;
      vlev    <= '0;
      ilev    <= '0;
    end else begin
      if (wr_mask) begin
        mask_oi <= wdata[OI_BIT];
        mask_ov <= wdata[OV_BIT];
      end
      if (wr_vlev) vlev <= wdata[LEVEL_W-1:0];
      if (wr_ilev) ilev <= wdata[LEVEL_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      RA_STATUS: begin
        rd_word[OI_BIT] = oi_flag;
        rd_word[OV_BIT] = ov_flag;
      end
      RA_PHASE: begin
        rd_word[OI_PH_LSB +: NUM_PH] = oi_ph;
        rd_word[OV_PH_LSB +: NUM_PH] = ov_ph;
      end
      RA_MASK: begin
        rd_word[OI_BIT] = mask_oi;
        rd_word[OV_BIT] = mask_ov;
      end
      RA_VLEVEL: rd_word[LEVEL_W-1:0] = vlev;
      RA_ILEVEL: rd_word[LEVEL_W-1:0] = ilev;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_word;
  end

  // R11
  level_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && (addr == RA_VLEVEL || addr == RA_ILEVEL)) |=> (rdata[REG_DW-1:LEVEL_W] == '0));
endmodule

// File: rtl/phase_overlevel_irq.sv
module phase_overlevel_irq
  import ovl_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int LEVEL_W    = 24,
  parameter int NUM_PH     = 3,
  parameter int FULL_SCALE = 5928256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PH*SAMPLE_W-1:0] v_smp,
  input  logic                       v_vld,
  input  logic [NUM_PH*SAMPLE_W-1:0] i_smp,
  input  logic                       i_vld,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_DW-1:0]          reg_wdata,
  output logic [REG_DW-1:0]          reg_rdata,
  output logic                       irq_n
);
  logic [NUM_PH-1:0]  v_hit, i_hit;
  logic [NUM_PH-1:0]  oi_ph, ov_ph;
  logic               oi_flag, ov_flag;
  logic               mask_oi, mask_ov;
  logic               clr_oi, clr_ov;
  logic [LEVEL_W-1:0] vlev, ilev;
  logic               irq_req;

  ovl_phase_cmp #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .NUM_PH(NUM_PH),
                  .FULL_SCALE(FULL_SCALE)) u_vcmp (
    .clk(clk), .rst(rst), .smp(v_smp), .vld(v_vld), .lvl(vlev), .hit(v_hit));

  ovl_phase_cmp #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W), .NUM_PH(NUM_PH),
                  .FULL_SCALE(FULL_SCALE)) u_icmp (
    .clk(clk), .rst(rst), .smp(i_smp), .vld(i_vld), .lvl(ilev), .hit(i_hit));

  ovl_sticky #(.NUM_PH(NUM_PH)) u_oi (
    .clk(clk), .rst(rst), .hit(i_hit), .clr(clr_oi), .flag(oi_flag), .phases(oi_ph));

  ovl_sticky #(.NUM_PH(NUM_PH)) u_ov (
    .clk(clk), .rst(rst), .hit(v_hit), .clr(clr_ov), .flag(ov_flag), .phases(ov_ph));

  ovl_regs #(.LEVEL_W(LEVEL_W), .NUM_PH(NUM_PH)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .wdata(reg_wdata),
    .oi_flag(oi_flag), .ov_flag(ov_flag), .oi_ph(oi_ph), .ov_ph(ov_ph),
    .mask_oi(mask_oi), .mask_ov(mask_ov), .vlev(vlev), .ilev(ilev),
    .clr_oi(clr_oi), .clr_ov(clr_ov), .rdata(reg_rdata));

  assign irq_req = (oi_flag && mask_oi) || (ov_flag && mask_ov);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~irq_req;
  end

  // R8
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    ((oi_flag && mask_oi) || (ov_flag && mask_ov)) |=> !irq_n);
  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    !((oi_flag && mask_oi) || (ov_flag && mask_ov)) |=> irq_n);
  // R3
  ov_phase_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_ph != '0) |-> ov_flag);
endmodule

// File: tb/sim_phase_overlevel_irq.sv
module sim_phase_overlevel_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [71:0] v_smp = '0;
  logic        v_vld = 1'b0;
  logic [71:0] i_smp = '0;
  logic        i_vld = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [31:0] OI = 32'h0002_0000;
  localparam logic [31:0] OV = 32'h0004_0000;

  always #4 clk = ~clk;

  phase_overlevel_irq u0 (
    .clk(clk), .rst(rst), .v_smp(v_smp), .v_vld(v_vld), .i_smp(i_smp), .i_vld(i_vld),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [71:0] pk(input int a, input int b, input int c);
    logic [23:0] ta, tb, tc;
    ta = 24'(a); tb = 24'(b); tc = 24'(c);
    return {tc, tb, ta};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic cur(input int a, input int b, input int c, input bit vld);
    @(negedge clk);
    i_smp = pk(a, b, c); i_vld = vld;
    @(negedge clk);
    i_vld = 1'b0;
  endtask

  task automatic volt(input int a, input int b, input int c, input bit vld);
    @(negedge clk);
    v_smp = pk(a, b, c); v_vld = vld;
    @(negedge clk);
    v_vld = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_n after reset", {31'b0, irq_n}, 32'd1);
    chk("R1 rdata after reset", reg_rdata, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 32'd0);
    end
  endtask

  task automatic t_levels;
    logic [31:0] d;
    wr_reg(3'd3, 32'hFF00_03E8);
    wr_reg(3'd4, 32'hAB00_07D0);
    rd_reg(3'd3, d);
    chk("R11 voltage level padded", d, 32'h0000_03E8);
    rd_reg(3'd4, d);
    chk("R11 current level padded", d, 32'h0000_07D0);
    wr_reg(3'd2, 32'hFFFF_FFFF);
    rd_reg(3'd2, d);
    chk("R11 mask keeps bits 17 and 18", d, OI | OV);
    wr_reg(3'd2, 32'h0);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    cur(-8000000, 8000000, 9000, 1'b0);
    volt(7000000, -7000000, 5000, 1'b0);
    rd_reg(3'd0, d);
    chk("R5 invalid samples leave status", d, 32'd0);
    rd_reg(3'd1, d);
    chk("R5 invalid samples leave phases", d, 32'd0);
  endtask

  task automatic t_current;
    logic [31:0] d;
    cur(1500, 2000, -2000, 1'b1);
    rd_reg(3'd0, d);
    chk("R2 equal magnitude not detected", d, 32'd0);
    cur(0, 2001, 0, 1'b1);
    rd_reg(3'd0, d);
    chk("R2 current over level sets bit 17", d, OI);
    rd_reg(3'd1, d);
    chk("R2 phase B at bit 4", d, 32'h10);
    cur(0, 0, -2500, 1'b1);
    rd_reg(3'd1, d);
    chk("R12 R4 phase C accumulates", d, 32'h30);
    chk("R8 masked off irq stays high", {31'b0, irq_n}, 32'd1);
  endtask

  task automatic t_mask_clear;
    logic [31:0] d;
    wr_reg(3'd2, OI);
    @(negedge clk);
    chk("R8 irq low with mask", {31'b0, irq_n}, 32'd0);
    wr_reg(3'd0, OV);
    rd_reg(3'd1, d);
    chk("R9 other bit write keeps phases", d, 32'h30);
    rd_reg(3'd0, d);
    chk("R9 other bit write keeps flag", d, OI);
    wr_reg(3'd0, OI);
    rd_reg(3'd0, d);
    chk("R9 clear drops flag", d, 32'd0);
    rd_reg(3'd1, d);
    chk("R9 clear drops phases", d, 32'd0);
    chk("R9 R8 irq released", {31'b0, irq_n}, 32'd1);
  endtask

  task automatic t_voltage;
    logic [31:0] d;
    volt(-1001, 1000, -1000, 1'b1);
    rd_reg(3'd0, d);
    chk("R3 R4 voltage sets bit 18", d, OV);
    rd_reg(3'd1, d);
    chk("R3 phase A at bit 9", d, 32'h200);
    wr_reg(3'd2, OV);
    @(negedge clk);
    chk("R8 voltage irq low", {31'b0, irq_n}, 32'd0);
    wr_reg(3'd0, OV);
    @(negedge clk);
    chk("R8 voltage irq released", {31'b0, irq_n}, 32'd1);
    wr_reg(3'd2, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    cur(3000, 0, 0, 1'b1);
    @(negedge clk);
    i_smp = pk(0, 0, 3000); i_vld = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = OI;
    @(negedge clk);
    i_vld = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(3'd0, d);
    chk("R10 race keeps flag", d, OI);
    rd_reg(3'd1, d);
    chk("R10 race keeps only new phase", d, 32'h20);
    wr_reg(3'd0, OI);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    wr_reg(3'd4, 32'd5928256);
    cur(-8388608, 8388607, -5928257, 1'b1);
    rd_reg(3'd0, d);
    chk("R6 full-scale level never detects", d, 32'd0);
    wr_reg(3'd4, 32'h7F_FFFF);
    cur(-8388608, 8388607, 0, 1'b1);
    rd_reg(3'd0, d);
    chk("R6 level above full scale never detects", d, 32'd0);
    wr_reg(3'd4, 32'd5928255);
    cur(-8388608, 0, 0, 1'b1);
    rd_reg(3'd1, d);
    chk("R4 most negative code detected", d, 32'h08);
    wr_reg(3'd0, OI);
    wr_reg(3'd4, 32'd0);
    cur(0, 0, 0, 1'b1);
    rd_reg(3'd0, d);
    chk("R7 zero level detects zero sample", d, OI);
    rd_reg(3'd1, d);
    chk("R7 zero level marks all phases", d, 32'h38);
    wr_reg(3'd0, OI | OV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_levels();
    t_ignore();
    t_current();
    t_mask_clear();
    t_voltage();
    t_race();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule